// File: doc/BRIEF.md
# Vector Unpack Destination Address Sequencer

This block steps through the destination slots of one vector-unpack command. A command arrives as a single-cycle start strobe carrying a vector count, a 10-bit starting quadword index, an element-size code, a component-count code, a cycle length, a write length, a double-buffer select and the current double-buffer top value. The block then presents one output vector per accepted handshake. Each vector carries a 16-byte aligned byte address inside a destination memory window. It also carries a flag that says whether the vector is synthesised (fill) or taken from the input stream (consume), and a per-lane enable that marks which 32-bit lanes carry converted data. Disabled lanes are to be written as zero.

When the command is captured, the block also works out how many 32-bit input words the command will draw from the input stream. Downstream conversion logic uses this count to check that enough data is present. The sequencer does not touch data. It only orders and places the vectors. A one-cycle completion pulse follows the last vector.

The destination window size is a parameter. A smaller and a larger instance, 4 KiB and 16 KiB, are expected. Addresses that pass the top of the window wrap back to its base.

Top module: `unpk_addr_seq`

## Requirements
- R1: A start strobe is captured only while no command is running. A strobe that arrives during a running command changes neither the vector sequence nor `words_need`.
- R2: A command yields `num` output vectors, with a `num` of 0 meaning 256. `vec_valid` is high from the cycle after capture until the last vector is accepted. `done` is high for exactly one cycle, the cycle after that acceptance, and `vec_valid` is low in that cycle.
- R3: The sequence advances only on a cycle where `vec_valid` and `vec_ready` are both high. While `vec_ready` is low, every vector output holds its value.
- R4: When `cl >= wl`, the quadword index of vector k is `imm + floor(k/W)*cl + (k mod W)`, where W is `wl`, with a `wl` of 0 meaning 256.
- R5: When `cl < wl`, the quadword index of vector k is `imm + k`. Vector k is a fill vector when `(k mod wl) >= cl`. `vec_consume` is the inverse of `vec_fill` for every vector.
- R6: A command with `num`, `cl` and `wl` all zero produces 256 vectors, every one a fill vector, and `words_need` is 0.
- R7: When `dbuf` is 1, `tops` is added to the quadword index after all other terms. When `dbuf` is 0, `tops` has no effect.
- R8: `vec_addr` is `BASE_ADDR + 16*(index mod (MEM_BYTES/16))`. This is the same as subtracting the window size until the address is below `BASE_ADDR + MEM_BYTES`.
- R9: `words_need` is `ceil((32>>vl)*(vn+1)*n/32)`. Here n is the vector count when `cl >= wl`, and `cl*floor(V/wl) + min(V mod wl, cl)` otherwise, with V the vector count.
- R10: `lane_en[i]` is 1 exactly when `i <= vn`, for lanes 0 to 3.
- R11: After reset, `vec_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe |
| num | input | 8 | Vector count, 0 means 256 |
| imm | input | 10 | Starting quadword index |
| vl | input | 2 | Element size code |
| vn | input | 2 | Component count minus one |
| cl | input | 8 | Cycle length |
| wl | input | 8 | Write length, 0 means 256 |
| dbuf | input | 1 | Add double-buffer top |
| tops | input | 10 | Double-buffer top, in quadwords |
| vec_ready | input | 1 | Downstream accepts the current vector |
| vec_valid | output | 1 | A vector is presented |
| vec_addr | output | ADDR_W | Byte address of the vector |
| vec_fill | output | 1 | Vector is synthesised, not read from input |
| vec_consume | output | 1 | Vector takes data from input |
| lane_en | output | 4 | Lanes carrying data; the others are zero |
| words_need | output | 11 | Input words used by the command |
| done | output | 1 | One-cycle completion pulse |

## Verification
The clock edge that captures `start` also registers `words_need`, and the first vector appears on the outputs in the cycle after that edge. The bench checks both one half-period after the capture edge. Each later vector is due one cycle after the edge that accepts its predecessor, and `done` is due one cycle after the edge that accepts the last vector. The bench's behavioural model therefore pops its expected queue only on edges where it drove `vec_ready` high, and it compares the queue head against the outputs at every falling edge. Stall patterns exercise the hold behaviour in the same cycle-by-cycle comparison.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  localparam int CNT_W  = 8;
  localparam int IMM_W  = 10;
  localparam int VCT_W  = CNT_W + 1;
  localparam int ROW_W  = 2 * CNT_W + 1;
  localparam int QSUM_W = ROW_W + 2;
  localparam int WC_W   = 11;
  localparam int LANES  = 4;

  typedef struct packed {
    logic [CNT_W-1:0] num;
    logic [IMM_W-1:0] imm;
    logic [1:0]       vl;
    logic [1:0]       vn;
    logic [CNT_W-1:0] cl;
    logic [CNT_W-1:0] wl;
    logic             dbuf;
    logic [IMM_W-1:0] tops;
  } unpk_cmd_t;
endpackage

// File: rtl/unpk_wcount.sv
module unpk_wcount
  import unpk_pkg::*;
(
  input  unpk_cmd_t       cmd,
  output logic [WC_W-1:0] words
);
  logic [VCT_W-1:0] vcnt, cl9, wl9, quo, rem, tail, n;
  logic [2*VCT_W-1:0] prod;
  logic [15:0] unit_bits, comps, total_bits;
  logic shortcut;

  always_comb begin
    vcnt     = (cmd.num == '0) ? VCT_W'(1 << CNT_W) : {1'b0, cmd.num};
    cl9      = {1'b0, cmd.cl};
    wl9      = {1'b0, cmd.wl};
    shortcut = (cmd.num == '0) && (cmd.cl == '0) && (cmd.wl == '0);
    quo  = '0;
    rem  = '0;
    tail = '0;
    prod = '0;
    if (shortcut) begin
      n = '0;
    end else if (cl9 >= wl9) begin
      n = vcnt;
    end else begin
      quo  = vcnt / wl9;
      rem  = vcnt % wl9;
      tail = (rem < cl9) ? rem : cl9;
      prod = {{VCT_W{1'b0}}, cl9} * {{VCT_W{1'b0}}, quo};
      n    = prod[VCT_W-1:0] + tail;
    end
    unit_bits  = 16'd32 >> cmd.vl;
    comps      = 16'({1'b0, cmd.vn}) + 16'd1;
    total_bits = unit_bits * comps * 16'(n);
    words      = WC_W'((total_bits + 16'd31) >> 5);
  end
endmodule

// File: rtl/unpk_walk.sv
module unpk_walk
  import unpk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [VCT_W-1:0] vcount_in,
  input  logic [VCT_W-1:0] wlen,
  input  logic [VCT_W-1:0] stride,
  output logic [VCT_W-1:0] col,
  output logic [ROW_W-1:0] rowb,
  output logic             last
);
  logic [VCT_W-1:0] col_q, col_d, left_q, left_d;
  logic [ROW_W-1:0] rowb_q, rowb_d;

  always_comb begin
    col_d  = col_q;
    rowb_d = rowb_q;
    left_d = left_q;
    if (load) begin
      col_d  = '0;
      rowb_d = '0;
      left_d = vcount_in;
    end else if (adv && (left_q != '0)) begin
      left_d = left_q - 1'b1;
      if (col_q == wlen - 1'b1) begin
        col_d  = '0;
        rowb_d = rowb_q + ROW_W'(stride);
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      rowb_q <= '0;
      left_q <= '0;
    end else begin
      col_q  <= col_d;
      rowb_q <= rowb_d;
      left_q <= left_d;
    end
  end

  assign col  = col_q;
  assign rowb = rowb_q;
  assign last = (left_q == VCT_W'(1));

  AST_COL_INSIDE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q != '0) && !load |-> col_q < wlen) else $error("col beyond row"); // R4
endmodule

// File: rtl/unpk_place.sv
module unpk_place
  import unpk_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                QW        = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [ROW_W-1:0]  rowb,
  input  logic [VCT_W-1:0]  col,
  input  logic              dbuf,
  input  logic [IMM_W-1:0]  tops,
  output logic [ADDR_W-1:0] addr
);
  logic [QSUM_W-1:0] qsum, qdb;
  logic [QW-1:0]     qmod;

  always_comb begin
    qsum = QSUM_W'(imm) + QSUM_W'(rowb) + QSUM_W'(col);
    qdb  = dbuf ? (qsum + QSUM_W'(tops)) : qsum;
  end

  generate
    if (QW < QSUM_W) begin : g_mask
      assign qmod = qdb[QW-1:0];
    end else begin : g_wide
      assign qmod = QW'(qdb);
    end
  endgenerate

  assign addr = BASE_ADDR + ADDR_W'({qmod, 4'b0000});
endmodule

// File: rtl/unpk_addr_seq.sv
module unpk_addr_seq
  import unpk_pkg::*;
#(
  parameter int                MEM_BYTES = 4096,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        num,
  input  logic [9:0]        imm,
  input  logic [1:0]        vl,
  input  logic [1:0]        vn,
  input  logic [7:0]        cl,
  input  logic [7:0]        wl,
  input  logic              dbuf,
  input  logic [9:0]        tops,
  input  logic              vec_ready,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              vec_fill,
  output logic              vec_consume,
  output logic [3:0]        lane_en,
  output logic [10:0]       words_need,
  output logic              done
);
  localparam int QDEPTH = MEM_BYTES / 16;
  localparam int QW     = $clog2(QDEPTH);

  logic [1:0] rsync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  unpk_cmd_t        cmd_in, cmd_q;
  logic [WC_W-1:0]  words_d, words_q;
  logic             busy_q, busy_d, done_q, done_d;
  logic             cmd_load, adv, last;
  logic [VCT_W-1:0] vcount_in, wlen_q, stride_q, col;
  logic [ROW_W-1:0] rowb;
  logic             cyc_mode, shortcut_q;

  always_comb begin
    cmd_in.num  = num;
    cmd_in.imm  = imm;
    cmd_in.vl   = vl;
    cmd_in.vn   = vn;
    cmd_in.cl   = cl;
    cmd_in.wl   = wl;
    cmd_in.dbuf = dbuf;
    cmd_in.tops = tops;
  end

  assign cmd_load  = start && !busy_q;
  assign adv       = busy_q && vec_ready;
  assign vcount_in = (num == '0) ? VCT_W'(1 << CNT_W) : {1'b0, num};

  always_comb begin
    wlen_q     = (cmd_q.wl == '0) ? VCT_W'(1 << CNT_W) : {1'b0, cmd_q.wl};
    cyc_mode   = (cmd_q.cl >= cmd_q.wl);
    stride_q   = cyc_mode ? {1'b0, cmd_q.cl} : wlen_q;
    shortcut_q = (cmd_q.num == '0) && (cmd_q.cl == '0) && (cmd_q.wl == '0);
  end

  unpk_wcount u_wcount (
    .cmd   (cmd_in),
    .words (words_d)
  );

  unpk_walk u_walk (
    .clk       (clk),
    .rst_n     (rst_sn),
    .load      (cmd_load),
    .adv       (adv),
    .vcount_in (vcount_in),
    .wlen      (wlen_q),
    .stride    (stride_q),
    .col       (col),
    .rowb      (rowb),
    .last      (last)
  );

  unpk_place #(
    .ADDR_W    (ADDR_W),
    .QW        (QW),
    .BASE_ADDR (BASE_ADDR)
  ) u_place (
    .imm  (cmd_q.imm),
    .rowb (rowb),
    .col  (col),
    .dbuf (cmd_q.dbuf),
    .tops (cmd_q.tops),
    .addr (vec_addr)
  );

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    if (cmd_load) begin
      busy_d = 1'b1;
    end else if (adv && last) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cmd_q   <= '0;
      words_q <= '0;
    end else if (cmd_load) begin
      cmd_q   <= cmd_in;
      words_q <= words_d;
    end
  end

  assign vec_valid   = busy_q;
  assign done        = done_q;
  assign words_need  = words_q;
  assign vec_fill    = shortcut_q || (!cyc_mode && (col >= {1'b0, cmd_q.cl}));
  assign vec_consume = !vec_fill;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = (cmd_q.vn >= 2'(i));
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_addr) && $stable(vec_fill))
    else $error("outputs moved while stalled"); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done) else $error("done longer than one cycle"); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> !vec_valid) else $error("valid during done"); // R2
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_sn)
    vec_valid && start |=> $stable(words_need)) else $error("start taken while busy"); // R1
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_sn)
    vec_valid |-> (32'(vec_addr) - 32'(BASE_ADDR)) < 32'(MEM_BYTES))
    else $error("address outside window"); // R8
endmodule

// File: tb/unpk_addr_seq_tb.sv
module unpk_addr_seq_tb_top;
  localparam int MEM = 4096;
  localparam int BASE = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] num = '0, cl = '0, wl = '0;
  logic [9:0] imm = '0, tops = '0;
  logic [1:0] vl = '0, vn = '0;
  logic dbuf = 1'b0, vec_ready = 1'b0;
  logic vec_valid, vec_fill, vec_consume, done;
  logic [15:0] vec_addr;
  logic [3:0] lane_en;
  logic [10:0] words_need;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  unpk_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .num(num), .imm(imm), .vl(vl), .vn(vn),
    .cl(cl), .wl(wl), .dbuf(dbuf), .tops(tops), .vec_ready(vec_ready),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_fill(vec_fill),
    .vec_consume(vec_consume), .lane_en(lane_en), .words_need(words_need), .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input string req, input int c_num, input int c_imm, input int c_vl,
                         input int c_vn, input int c_cl, input int c_wl, input int c_db,
                         input int c_tops, input int stall, input bit poke);
    int exp_addr[$];
    int exp_fill[$];
    int vcnt, wla, nin, words, lanes, cyc;
    bit cycm, shortc;
    vcnt   = (c_num == 0) ? 256 : c_num;
    wla    = (c_wl == 0) ? 256 : c_wl;
    cycm   = (c_cl >= c_wl);
    shortc = (c_num == 0) && (c_cl == 0) && (c_wl == 0);
    for (int k = 0; k < vcnt; k++) begin
      int q, a;
      if (cycm) q = c_imm + (k / wla) * c_cl + (k % wla);
      else      q = c_imm + k;
      if (c_db != 0) q = q + c_tops;
      a = BASE + 16 * q;
      while (a >= BASE + MEM) a = a - MEM;
      exp_addr.push_back(a);
      exp_fill.push_back((shortc || (!cycm && ((k % c_wl) >= c_cl))) ? 1 : 0);
    end
    if (shortc) nin = 0;
    else if (cycm) nin = vcnt;
    else nin = c_cl * (vcnt / c_wl) + (((vcnt % c_wl) < c_cl) ? (vcnt % c_wl) : c_cl);
    words = ((32 >> c_vl) * (c_vn + 1) * nin + 31) / 32;
    lanes = (1 << (c_vn + 1)) - 1;

    @(negedge clk);
    start = 1'b1; num = 8'(c_num); imm = 10'(c_imm); vl = 2'(c_vl); vn = 2'(c_vn);
    cl = 8'(c_cl); wl = 8'(c_wl); dbuf = c_db[0]; tops = 10'(c_tops);
    @(negedge clk);
    start = 1'b0;
    chk("R9", {req, " words_need"}, words_need, words);
    chk("R10", {req, " lane_en"}, lane_en, lanes);
    cyc = 0;
    while (exp_addr.size() > 0) begin
      chk("R2", {req, " valid"}, vec_valid, 1);
      chk("R8", {req, " addr"}, vec_addr, exp_addr[0]);
      chk("R5", {req, " fill"}, vec_fill, exp_fill[0]);
      chk("R5", {req, " consume"}, vec_consume, 1 - exp_fill[0]);
      vec_ready = (stall != 0) ? ((cyc % 3) != 2) : 1'b1;
      if (poke && cyc == 2) begin
        start = 1'b1; num = 8'd1; imm = 10'd3; cl = 8'd9; wl = 8'd1; vn = 2'd0; vl = 2'd3;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      if (vec_ready) begin
        void'(exp_addr.pop_front());
        void'(exp_fill.pop_front());
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    vec_ready = 1'b0;
    chk("R2", {req, " done pulse"}, done, 1);
    chk("R2", {req, " valid after last"}, vec_valid, 0);
    if (poke) chk("R1", {req, " words kept"}, words_need, words);
    @(negedge clk);
    chk("R2", {req, " done falls"}, done, 0);
    chk("R1", {req, " stays idle"}, vec_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "valid after reset", vec_valid, 0);
    chk("R11", "done after reset", done, 0);
    // R4 skip-write stepping
    run_cmd("R4 cycle", 6, 5, 0, 3, 4, 2, 0, 0, 0, 0);
    // R5 fill stepping with stalls (R3 hold)
    run_cmd("R5 fill R3", 7, 100, 1, 1, 2, 3, 0, 0, 1, 0);
    // R4 equal lengths
    run_cmd("R4 equal", 4, 20, 2, 2, 3, 3, 0, 0, 0, 0);
    // R4 write length 0 means 256, R2 count 0 means 256
    run_cmd("R4 wl0 R2 n256", 0, 7, 0, 0, 5, 0, 0, 0, 1, 0);
    // R6 all-zero shortcut
    run_cmd("R6 shortcut", 0, 30, 0, 3, 0, 0, 0, 0, 0, 0);
    // R7 double buffer with R8 wrap
    run_cmd("R7 R8 wrap", 10, 1000, 0, 3, 200, 1, 1, 900, 0, 0);
    // R7 tops ignored without dbuf
    run_cmd("R7 no dbuf", 3, 40, 0, 1, 1, 1, 0, 700, 0, 0);
    // R1 start during a run
    run_cmd("R1 poke", 5, 60, 1, 2, 2, 2, 0, 0, 1, 1);
    // R9 rounding to a whole word
    run_cmd("R9 round", 5, 0, 2, 2, 1, 1, 0, 0, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule